// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a missing translation. It walks a two-level page table held in memory, the way a hardware refill engine fills a translation cache. A request carries a 32-bit virtual address and the frame number of the top-level table. The walker splits the address into a 10-bit top index, a 10-bit second-level index and a 12-bit page offset. It then reads the top-level entry through a word-wide memory port.

If that entry is marked present, the walker takes the frame of the second-level table from it and reads the leaf entry. A present leaf entry is returned as-is, together with the physical address: the leaf frame number joined to the unchanged offset. An absent entry at either level ends the walk with a fault. The fault response names the level and carries the faulting virtual address. An absent top-level entry stops the walk before any second-level read is issued.

The walker serves one walk at a time. It accepts a request only while idle and holds `busy` high until its one-cycle response.

Top module: `ptw_two_level`

## Requirements
- R1: After reset the walker is idle: `busy`=0, `req_ready`=1, `mem_req_valid`=0, `resp_valid`=0.
- R2: The first read of a walk uses word address {`req_root`, vaddr[31:22]}, that is, byte address root*4096 + 4*top index.
- R3: If bit 0 of the top-level entry is 0, the walk ends with `resp_fault`=1 and `resp_fault_level`=0 after exactly one read, and `resp_vaddr` equals the requested address.
- R4: If bit 0 of the top-level entry is 1, the second read uses word address {entry[31:12], vaddr[21:12]}.
- R5: If bit 0 of the leaf entry is 0, the walk ends with `resp_fault`=1 and `resp_fault_level`=1 after exactly two reads, and `resp_vaddr` equals the requested address.
- R6: If bit 0 of the leaf entry is 1, the response has `resp_fault`=0, `resp_pte` equal to the leaf word, and `resp_paddr` = {leaf[31:12], vaddr[11:0]}. For example, 0x18007 with leaf frame 0x148 gives 0x148007.
- R7: A memory request stays asserted with a stable address until `mem_req_ready` is seen, and each level is read exactly once.
- R8: From acceptance until the response, `busy`=1 and `req_ready`=0. Requests presented meanwhile are ignored: they change neither the response nor the reads, and no walk follows.
- R9: Only bit 0 decides validity at either level. The leaf fields are passed through unchanged in `resp_pte`: protection R/W/X in [11:9], modify in [2], reference in [1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Virtual address to translate |
| req_root | input | 20 | Frame number of the top-level table |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 30 | Word address of the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| resp_valid | output | 1 | One-cycle walk result |
| resp_fault | output | 1 | Walk hit an absent entry |
| resp_fault_level | output | 1 | 0 = top level, 1 = leaf level |
| resp_pte | output | 32 | Last entry read |
| resp_paddr | output | 32 | Translated physical address |
| resp_vaddr | output | 32 | Virtual address of the walk |

## Verification
The bench sweeps every top-level index. Absent entries are mixed into both table levels, and the entries carry noise in their flag bits. A walker that tested the wrong bit, or let the flag bits decide, would then fault or translate wrongly. A walker that read the leaf table after an absent top entry would show a second read where the bench expects exactly one. The bench also stalls the memory port for several cycles, to catch a request that drops or changes its address while waiting. It presents a competing request during a walk, to catch a walker that re-accepts early or corrupts its captured address. The worked translation 0x18007 to 0x148007 pins the joining of frame and offset.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_L1_REQ  = 3'd1,
        ST_L1_WAIT = 3'd2,
        ST_L2_REQ  = 3'd3,
        ST_L2_WAIT = 3'd4,
        ST_RESP    = 3'd5
    } walk_st_e;

    localparam int ENTRY_PRESENT_BIT = 0;
endpackage

// File: rtl/ptw_idx_addr.sv
module ptw_idx_addr #(
    parameter int FRAME_W = 20,
    parameter int IDX_W   = 10
) (
    input  logic [FRAME_W-1:0]       base_frame,
    input  logic [IDX_W-1:0]         index,
    output logic [FRAME_W+IDX_W-1:0] word_addr
);
    always_comb begin
        word_addr = {base_frame, index};
    end
endmodule

// File: rtl/ptw_paddr_join.sv
module ptw_paddr_join #(
    parameter int FRAME_W = 20,
    parameter int OFF_W   = 12
) (
    input  logic [FRAME_W-1:0]       frame,
    input  logic [OFF_W-1:0]         offset,
    output logic [FRAME_W+OFF_W-1:0] paddr
);
    always_comb begin
        paddr = {frame, offset};
    end
endmodule

// File: rtl/ptw_two_level.sv
module ptw_two_level #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    localparam int VA_W    = 2 * IDX_W + OFF_W,
    localparam int FRAME_W = VA_W - OFF_W,
    localparam int MEM_AW  = FRAME_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [FRAME_W-1:0] req_root,
    output logic               busy,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [MEM_AW-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [VA_W-1:0]    mem_rsp_data,
    output logic               resp_valid,
    output logic               resp_fault,
    output logic               resp_fault_level,
    output logic [VA_W-1:0]    resp_pte,
    output logic [VA_W-1:0]    resp_paddr,
    output logic [VA_W-1:0]    resp_vaddr
);
    import ptw_pkg::*;

    typedef struct packed {
        walk_st_e           st;
        logic [VA_W-1:0]    va;
        logic [FRAME_W-1:0] root;
        logic [FRAME_W-1:0] sbase;
        logic [VA_W-1:0]    pte;
        logic               fault;
        logic               lvl;
    } walk_s;

    walk_s q, d;

    logic [FRAME_W-1:0] lvl_base [2];
    logic [MEM_AW-1:0]  lvl_addr [2];
    logic               rsp_present;

    assign lvl_base[0] = q.root;
    assign lvl_base[1] = q.sbase;
    assign rsp_present = mem_rsp_data[ENTRY_PRESENT_BIT];

    for (genvar g = 0; g < 2; g++) begin : g_level
        ptw_idx_addr #(
            .FRAME_W(FRAME_W),
            .IDX_W  (IDX_W)
        ) i_idx_addr (
            .base_frame(lvl_base[g]),
            .index     (q.va[VA_W-1-g*IDX_W -: IDX_W]),
            .word_addr (lvl_addr[g])
        );
    end

    ptw_paddr_join #(
        .FRAME_W(FRAME_W),
        .OFF_W  (OFF_W)
    ) i_paddr_join (
        .frame (q.pte[VA_W-1:OFF_W]),
        .offset(q.va[OFF_W-1:0]),
        .paddr (resp_paddr)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_L1_REQ;
                    d.va    = req_vaddr;
                    d.root  = req_root;
                    d.pte   = '0;
                    d.fault = 1'b0;
                    d.lvl   = 1'b0;
                end
            end
            ST_L1_REQ: begin
                if (mem_req_ready) d.st = ST_L1_WAIT;
            end
            ST_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    if (rsp_present) begin
                        d.sbase = mem_rsp_data[VA_W-1:OFF_W];
                        d.st    = ST_L2_REQ;
                    end else begin
                        d.pte   = mem_rsp_data;
                        d.fault = 1'b1;
                        d.lvl   = 1'b0;
                        d.st    = ST_RESP;
                    end
                end
            end
            ST_L2_REQ: begin
                if (mem_req_ready) d.st = ST_L2_WAIT;
            end
            ST_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    d.pte   = mem_rsp_data;
                    d.fault = !rsp_present;
                    d.lvl   = 1'b1;
                    d.st    = ST_RESP;
                end
            end
            ST_RESP: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready        = (q.st == ST_IDLE);
    assign busy             = (q.st != ST_IDLE);
    assign mem_req_valid    = (q.st == ST_L1_REQ) || (q.st == ST_L2_REQ);
    assign mem_req_addr     = (q.st == ST_L2_REQ) ? lvl_addr[1] : lvl_addr[0];
    assign resp_valid       = (q.st == ST_RESP);
    assign resp_fault       = q.fault;
    assign resp_fault_level = q.lvl;
    assign resp_pte         = q.pte;
    assign resp_vaddr       = q.va;

    // R1: an idle walker drives no request and no response
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req_valid && !resp_valid));

    // R3: an absent top entry ends the walk at level 0 with no further read
    p_l1_fault_no_l2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_L1_WAIT && mem_rsp_valid && !mem_rsp_data[0])
        |=> (resp_valid && resp_fault && !resp_fault_level && !mem_req_valid));

    // R4: the leaf read uses the frame taken from the top entry
    p_l2_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_L1_WAIT && mem_rsp_valid && mem_rsp_data[0])
        |=> (mem_req_valid
             && mem_req_addr[MEM_AW-1:IDX_W] == $past(mem_rsp_data[VA_W-1:OFF_W])
             && mem_req_addr[IDX_W-1:0] == resp_vaddr[OFF_W+IDX_W-1:OFF_W]));

    // R6: a successful walk returns a present leaf whose frame forms the address
    p_ok_join_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault)
        |-> (resp_pte[0] && resp_paddr[VA_W-1:OFF_W] == resp_pte[VA_W-1:OFF_W]));

    // R7: a stalled memory request holds its address
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R8: no acceptance while a walk is in progress
    p_busy_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);
endmodule

// File: tb/test_ptw_two_level.sv
`timescale 1ns/1ps
module test_ptw_two_level;
    localparam logic [19:0] ROOT = 20'hABCDE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [19:0] req_root = '0;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [29:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        resp_valid, resp_fault, resp_fault_level;
    logic [31:0] resp_pte, resp_paddr, resp_vaddr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    int          rd_cnt = 0;
    logic [29:0] rd_addr [2];
    int          stall_cfg = 0;
    int          stall_left = 0;
    int          stall_seen = 0;
    int          stable_err = 0;
    bit          have_hold = 0;
    logic [29:0] hold_addr = '0;
    bit          pend = 0;
    logic [29:0] pend_addr = '0;

    always #10 clk = ~clk;

    ptw_two_level i_ptw_two_level (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .resp_valid(resp_valid),
        .resp_fault(resp_fault), .resp_fault_level(resp_fault_level),
        .resp_pte(resp_pte), .resp_paddr(resp_paddr), .resp_vaddr(resp_vaddr)
    );

    function automatic logic [31:0] mem_word(input logic [29:0] a);
        logic [9:0]  midx;
        logic [19:0] fr;
        if (a == {ROOT, 10'd0}) return 32'h0005_0001;
        if (a == {20'h00050, 10'h018}) return {20'h00148, 3'b101, 6'h0, 2'b10, 1'b1};
        if (a[29:10] == ROOT) begin
            midx = a[9:0];
            fr   = 20'(32'h100 + 32'(midx) * 7);
            return {fr, 11'(midx ^ 10'h2A5), ((midx % 5) != 0)};
        end
        fr = 20'(a[19:0] * 3 + 20'h5);
        return {fr, a[2:0], 6'h0, a[4:3], ((a % 3) != 0)};
    endfunction

    // memory model: decides ready and answers on falling edges
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem_word(pend_addr);
            pend = 0;
        end
        if (mem_req_valid) begin
            if (stall_left > 0) begin
                mem_req_ready = 1'b0;
                stall_left--;
                stall_seen++;
                if (have_hold && mem_req_addr != hold_addr) stable_err++;
                hold_addr = mem_req_addr;
                have_hold = 1;
            end else begin
                if (have_hold && mem_req_addr != hold_addr) stable_err++;
                mem_req_ready = 1'b1;
                if (rd_cnt < 2) rd_addr[rd_cnt] = mem_req_addr;
                rd_cnt++;
                pend      = 1;
                pend_addr = mem_req_addr;
                have_hold = 0;
                stall_left = stall_cfg;
            end
        end else begin
            mem_req_ready = 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic walk(input logic [31:0] va, input int stall, input bit poke);
        logic [31:0] m, s;
        logic [29:0] a0, a1;
        int  exp_rd, bad_busy, poke_left;
        bit  got, exp_fault, exp_lvl;
        @(negedge clk);
        rd_cnt = 0; stall_cfg = stall; stall_left = stall; stall_seen = 0;
        stable_err = 0; have_hold = 0;
        req_valid = 1'b1; req_vaddr = va; req_root = ROOT;
        @(negedge clk);
        poke_left = poke ? 2 : 0;
        req_valid = poke; req_vaddr = ~va; req_root = ~ROOT;
        got = 0; bad_busy = 0;
        for (int c = 0; c < 60 && !got; c++) begin
            if (resp_valid) got = 1;
            else begin
                if (!busy || req_ready) bad_busy++;
                if (poke_left > 0) poke_left--;
                if (poke_left == 0) req_valid = 1'b0;
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        a0 = {ROOT, va[31:22]};
        m  = mem_word(a0);
        a1 = {m[31:12], va[21:12]};
        s  = mem_word(a1);
        if (!m[0]) begin exp_rd = 1; exp_fault = 1; exp_lvl = 0; end
        else begin exp_rd = 2; exp_fault = !s[0]; exp_lvl = 1; end
        chk(got, "R8 response arrives", 32'(got), 32'd1);
        chk(bad_busy == 0, "R8 busy and not ready during walk", 32'(bad_busy), 32'd0);
        chk(rd_cnt == exp_rd, exp_rd == 1 ? "R3 single read" : "R7 two reads",
            32'(rd_cnt), 32'(exp_rd));
        chk(rd_addr[0] == a0, "R2 top read address", 32'(rd_addr[0]), 32'(a0));
        if (exp_rd == 2)
            chk(rd_addr[1] == a1, "R4 leaf read address", 32'(rd_addr[1]), 32'(a1));
        chk(resp_fault == exp_fault, exp_lvl ? "R5 fault flag" : "R3 fault flag",
            32'(resp_fault), 32'(exp_fault));
        if (exp_fault) begin
            chk(resp_fault_level == exp_lvl, exp_lvl ? "R5 fault level" : "R3 fault level",
                32'(resp_fault_level), 32'(exp_lvl));
            chk(resp_vaddr == va, "R3 R5 fault address", resp_vaddr, va);
        end else begin
            chk(resp_pte == s, "R9 leaf passed through", resp_pte, s);
            chk(resp_paddr == {s[31:12], va[11:0]}, "R6 physical address",
                resp_paddr, {s[31:12], va[11:0]});
        end
        if (stall > 0) begin
            chk(stable_err == 0 && stall_seen == stall * exp_rd, "R7 stalled request held",
                32'(stall_seen), 32'(stall * exp_rd));
        end
        @(negedge clk);
        if (poke) chk(!busy && !mem_req_valid, "R8 ignored request started no walk",
                      32'(busy), 32'd0);
        stall_cfg = 0; stall_left = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && req_ready && !mem_req_valid && !resp_valid, "R1 reset idle",
            {28'h0, busy, req_ready, mem_req_valid, resp_valid}, 32'h4);

        // worked example: 0x18007 -> 0x148007
        walk(32'h0001_8007, 0, 0);
        chk(resp_paddr == 32'h0014_8007, "R6 example translation", resp_paddr, 32'h0014_8007);

        // sweep of every top-level index
        for (int i = 0; i < 1024; i++) begin
            walk({10'(i), 10'((i * 37 + 11) % 1024), 12'((i * 291) % 4096)}, 0, 0);
        end

        // stalled memory port, top-level fault and success cases
        walk({10'd5, 10'd7, 12'h123}, 3, 0);
        walk({10'd1, 10'd1, 12'hABC}, 4, 0);
        walk({10'd2, 10'd3, 12'h456}, 2, 0);

        // competing requests while busy
        walk({10'd0, 10'h018, 12'h007}, 0, 1);
        walk({10'd10, 10'd4, 12'h001}, 1, 1);
        walk({10'd7, 10'd9, 12'hFFF}, 0, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule